// File: doc/BRIEF.md
# Dual-Channel Per-Core Event Timer

This block gives each of two processor cores its own one-shot event timer behind a single 32-bit register bus. Every channel has a control word, a writable 32-bit up-counter and a 32-bit match value. A per-channel prescaler turns the input clock into count ticks, with a programmable ratio held in the upper half of the control word. When a tick carries the counter onto its match value, the channel's bit in a shared status register sets. The channel's interrupt line follows that bit.

To arm an event, software zeroes the counter, loads the delta into match and then starts the channel. Inside its handler it acknowledges the event by writing a one to its status bit, and it usually stops the channel there. Writing zero to a status bit has no effect. The counter does not stop at match: it keeps running and wraps modulo 2^32.

Top module: `core_event_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, both channels are stopped and both `irq` bits are low.
- R2: Register offsets are: control of channel i at 0x00+4i, match at 0x18+4i, counter at 0x48+4i, shared status at 0x60. Control reads back its bits [31:16] and [2:0], and bits [15:3] read zero. Match and counter read back their current values. Any other offset reads zero.
- R3: Control bits [31:16] hold a divider N. While the run bit (control bit 0) is set, the counter advances by one on every (N+1)-th clock edge. The first advance comes N+1 edges after the edge that sets the run bit.
- R4: While the run bit is clear, the counter holds its value.
- R5: A bus write to a counter loads the written value on that edge, even if a tick falls on the same edge. It also restarts the prescaler, so the next advance comes N+1 edges later.
- R6: Status bit i sets only on a tick that moves counter i onto match i, and only while control bit 1 (event enable) is set.
- R7: `irq[i]` is high exactly when status bit i is set and control bit 2 (interrupt enable) of channel i is set.
- R8: Writing to the status offset clears each bit that is written as 1 and leaves each bit written as 0 unchanged.
- R9: If a match event and a status clear for the same bit fall on the same edge, the bit ends up set.
- R10: The counter wraps from 0xFFFFFFFF to 0. A match value of 0 fires on that wrap. One equality produces exactly one status set.
- R11: The two channels are independent: activity on one leaves the other's counter, status bit and `irq` line unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and the timers |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 2 | Interrupt line per channel |

## Verification
Two functions can land on the same edge: the hardware setting a status bit on a match, and software clearing that same bit through the bus. The bench starts a channel with divider zero and a match three ticks away, then times a one-written status write so it is captured on the exact edge where the counter reaches match. It then expects the bit and the interrupt still set. The bench also lines up a counter write with a running prescaler to confirm that the written value wins over the tick.

// File: rtl/timer_pkg.sv
// Package: register offsets, control bit positions and widths shared
// by the event timer modules. Assumes a 32-bit data bus.
package timer_pkg;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned DIV_LSB    = 16;
    localparam int unsigned DIV_W      = DATA_W - DIV_LSB;
    localparam int unsigned CTL_RUN    = 0;
    localparam int unsigned CTL_HIT_EN = 1;
    localparam int unsigned CTL_IRQ_EN = 2;
    localparam int unsigned OFS_CTRL   = 'h00;
    localparam int unsigned OFS_MATCH  = 'h18;
    localparam int unsigned OFS_COUNT  = 'h48;
    localparam int unsigned OFS_STATUS = 'h60;
    localparam int unsigned OFS_STRIDE = 4;
endpackage

// File: rtl/tick_prescaler.sv
// Module: tick_prescaler
// Divides the clock into one tick every DIV+1 cycles while enabled.
// Assumes: a restart or a disable returns the phase to zero, so the first
// tick after either comes DIV+1 edges later.
module tick_prescaler #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase;

    assign tick = enable && !restart && (phase == div);

    // Phase counter: counts 0..div, held at zero when idle or restarted.
    always_ff @(posedge clk) begin
        if (!rst_n)                   phase <= '0;
        else if (!enable || restart)  phase <= '0;
        else if (phase == div)        phase <= '0;
        else                          phase <= phase + 1'b1;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || div == '0));  // R3
endmodule

// File: rtl/match_channel.sv
// Module: match_channel
// One timer channel: prescaler, loadable up-counter and match compare.
// Assumes: a counter write takes precedence over a tick on the same edge.
// The hit pulse is raised in the cycle whose tick moves the counter onto match.
module match_channel #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hit_en,
    input  logic [DIV_W-1:0] div,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] match,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    logic             tick;
    logic [CNT_W-1:0] count_next;

    tick_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (run),
        .restart (cnt_we),
        .div     (div),
        .tick    (tick)
    );

    assign count_next = count + 1'b1;
    assign hit        = tick && hit_en && (count_next == match);

    // Counter register: bus load first, else advance on tick, wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (cnt_we)  count <= cnt_wdata;
        else if (tick)    count <= count_next;
    end

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_we) |=> $stable(count));  // R4
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_we && $past(count) != count) |-> (count == $past(count) + 1'b1 || $past(cnt_we)));  // R3
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> count == $past(cnt_wdata));  // R5
    AST_HIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> count == $past(match));  // R6
endmodule

// File: rtl/core_event_timer.sv
// Module: core_event_timer
// NCH one-shot event timers with a shared write-one-to-clear status register
// and one interrupt line per channel, behind a simple 32-bit register bus.
// Assumes: bus reads are combinational on bus_addr; writes take effect on the
// rising edge with bus_wr high. NCH must not exceed 6, so the control block
// does not run into the match block.
module core_event_timer #(
    parameter int unsigned NCH    = 2,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [timer_pkg::DATA_W-1:0] bus_wdata,
    output logic [timer_pkg::DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]              irq
);
    import timer_pkg::*;

    logic [NCH-1:0]    run, hit_en, irq_en, hit, status, cnt_we;
    logic [DIV_W-1:0]  div     [NCH];
    logic [DATA_W-1:0] match_q [NCH];
    logic [DATA_W-1:0] count   [NCH];
    logic              wr_status;

    assign wr_status = bus_wr && (bus_addr == ADDR_W'(OFS_STATUS));

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic wr_ctrl, wr_match;
        assign wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL  + OFS_STRIDE * g));
        assign wr_match  = bus_wr && (bus_addr == ADDR_W'(OFS_MATCH + OFS_STRIDE * g));
        assign cnt_we[g] = bus_wr && (bus_addr == ADDR_W'(OFS_COUNT + OFS_STRIDE * g));

        // Control fields of this channel: enables and divider.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run[g]    <= 1'b0;
                hit_en[g] <= 1'b0;
                irq_en[g] <= 1'b0;
                div[g]    <= '0;
            end else if (wr_ctrl) begin
                run[g]    <= bus_wdata[CTL_RUN];
                hit_en[g] <= bus_wdata[CTL_HIT_EN];
                irq_en[g] <= bus_wdata[CTL_IRQ_EN];
                div[g]    <= bus_wdata[DATA_W-1:DIV_LSB];
            end
        end

        // Match value of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)        match_q[g] <= '0;
            else if (wr_match) match_q[g] <= bus_wdata;
        end

        match_channel #(.CNT_W(DATA_W), .DIV_W(DIV_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run[g]),
            .hit_en    (hit_en[g]),
            .div       (div[g]),
            .cnt_we    (cnt_we[g]),
            .cnt_wdata (bus_wdata),
            .match     (match_q[g]),
            .count     (count[g]),
            .hit       (hit[g])
        );

        // Status bit: a match event sets it and outranks a same-edge clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                         status[g] <= 1'b0;
            else if (hit[g])                    status[g] <= 1'b1;
            else if (wr_status && bus_wdata[g]) status[g] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> status[g]);  // R9
        AST_STATUS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[g]) |-> $past(hit[g]));  // R6
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_status && bus_wdata[g] && !hit[g]) |=> !status[g]);  // R8
        AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_status && !bus_wdata[g] && status[g]) |=> status[g]);  // R8
        AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> (status[g] && irq_en[g]));  // R7
    end

    assign irq = status & irq_en;

    // Read mux: decode the offset to one register, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_STATUS))
            bus_rdata = DATA_W'(status);
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ADDR_W'(OFS_CTRL + OFS_STRIDE * i)) begin
                bus_rdata[DATA_W-1:DIV_LSB] = div[i];
                bus_rdata[CTL_RUN]          = run[i];
                bus_rdata[CTL_HIT_EN]       = hit_en[i];
                bus_rdata[CTL_IRQ_EN]       = irq_en[i];
            end
            if (bus_addr == ADDR_W'(OFS_MATCH + OFS_STRIDE * i)) bus_rdata = match_q[i];
            if (bus_addr == ADDR_W'(OFS_COUNT + OFS_STRIDE * i)) bus_rdata = count[i];
        end
    end
endmodule

// File: tb/test_core_event_timer.sv
module test_core_event_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [7:0] A_CTL0 = 8'h00, A_CTL1 = 8'h04, A_MAT0 = 8'h18, A_MAT1 = 8'h1C,
                           A_CNT0 = 8'h48, A_CNT1 = 8'h4C, A_STAT = 8'h60;

    always #2.5 clk = ~clk;

    core_event_timer i_core_event_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called at a negedge; write captured on the next posedge; returns at the following negedge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_check(input string req, input string what, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, what, v, exp);
    endtask

    task automatic quiet_all();
        wr(A_CTL0, 0); wr(A_CTL1, 0); wr(A_STAT, 32'hFFFF);
    endtask

    task automatic t_reset();
        rd_check("R1", "ctrl0", A_CTL0, 0);
        rd_check("R1", "ctrl1", A_CTL1, 0);
        rd_check("R1", "match0", A_MAT0, 0);
        rd_check("R1", "count1", A_CNT1, 0);
        rd_check("R1", "status", A_STAT, 0);
        check("R1", "irq", {30'b0, irq}, 0);
    endtask

    task automatic t_readback();
        wr(A_MAT0, 32'h1234_5678);
        rd_check("R2", "match0 readback", A_MAT0, 32'h1234_5678);
        wr(A_CTL1, 32'hFFFF_FFFF);
        rd_check("R2", "ctrl1 reserved bits", A_CTL1, 32'hFFFF_0007);
        wr(A_CTL1, 0);
        wr(A_CNT1, 32'h0000_A5A5);
        rd_check("R2", "count1 readback", A_CNT1, 32'h0000_A5A5);
        rd_check("R2", "reserved 0x08", 8'h08, 0);
        rd_check("R2", "reserved 0x64", 8'h64, 0);
        rd_check("R2", "reserved 0x50", 8'h50, 0);
        quiet_all();
    endtask

    task automatic t_divider();
        wr(A_CNT0, 0); wr(A_MAT0, 1000);
        wr(A_CTL0, {16'd3, 16'h0001});
        edges(8);  rd_check("R3", "count after 8 edges, N=3", A_CNT0, 2);
        edges(3);  rd_check("R3", "count after 11 edges, N=3", A_CNT0, 2);
        edges(1);  rd_check("R3", "count after 12 edges, N=3", A_CNT0, 3);
        quiet_all();
    endtask

    task automatic t_stop();
        logic [31:0] v;
        wr(A_CNT0, 0); wr(A_CTL0, 32'h1);
        edges(4);
        wr(A_CTL0, 0);
        rd(A_CNT0, v);
        edges(6);
        rd_check("R4", "count held while stopped", A_CNT0, v);
        check("R4", "count advanced before stop", {31'b0, v != 0}, 1);
        quiet_all();
    endtask

    task automatic t_load();
        wr(A_MAT0, 32'hFFFF_0000);
        wr(A_CNT0, 0); wr(A_CTL0, {16'd3, 16'h0001});
        edges(7);
        wr(A_CNT0, 50);
        rd_check("R5", "load wins", A_CNT0, 50);
        edges(3); rd_check("R5", "prescaler restarted", A_CNT0, 50);
        edges(1); rd_check("R5", "first tick after load", A_CNT0, 51);
        quiet_all();
    endtask

    task automatic t_hit();
        wr(A_CNT0, 0); wr(A_MAT0, 5); wr(A_CTL0, 32'h7);
        edges(4);
        rd_check("R6", "status before match", A_STAT, 0);
        check("R7", "irq before match", {30'b0, irq}, 0);
        edges(1);
        rd_check("R6", "status at match", A_STAT, 1);
        rd_check("R6", "count at match", A_CNT0, 5);
        check("R7", "irq0 at match", {30'b0, irq}, 1);
        wr(A_STAT, 0);
        rd_check("R8", "write 0 keeps", A_STAT, 1);
        wr(A_STAT, 2);
        rd_check("R8", "other bit write keeps", A_STAT, 1);
        wr(A_STAT, 1);
        rd_check("R8", "write 1 clears", A_STAT, 0);
        check("R7", "irq after clear", {30'b0, irq}, 0);
        edges(10);
        rd_check("R10", "no refire past match", A_STAT, 0);
        quiet_all();
    endtask

    task automatic t_gates();
        wr(A_CNT0, 0); wr(A_MAT0, 3); wr(A_CTL0, 32'h1);
        edges(6);
        rd_check("R6", "no set without event enable", A_STAT, 0);
        rd_check("R3", "count ran", A_CNT0, 6);
        wr(A_CTL0, 0); wr(A_CNT0, 0); wr(A_CTL0, 32'h3);
        edges(4);
        rd_check("R6", "set with event enable", A_STAT, 1);
        check("R7", "irq masked", {30'b0, irq}, 0);
        wr(A_CTL0, 32'h7);
        check("R7", "irq unmasked", {30'b0, irq}, 1);
        quiet_all();
    endtask

    task automatic t_set_wins();
        wr(A_CNT1, 0); wr(A_MAT1, 3); wr(A_CTL1, 32'h7);
        edges(2);
        wr(A_STAT, 32'h2);
        rd_check("R9", "set beats same-edge clear", A_STAT, 2);
        check("R9", "irq1 kept", {30'b0, irq}, 2);
        quiet_all();
    endtask

    task automatic t_wrap();
        wr(A_CNT0, 32'hFFFF_FFFE); wr(A_MAT0, 0); wr(A_CTL0, 32'h3);
        edges(1);
        rd_check("R10", "count at top", A_CNT0, 32'hFFFF_FFFF);
        rd_check("R10", "no fire before wrap", A_STAT, 0);
        edges(1);
        rd_check("R10", "count wrapped", A_CNT0, 0);
        rd_check("R10", "fires on wrap", A_STAT, 1);
        wr(A_STAT, 1);
        edges(5);
        rd_check("R10", "single fire", A_STAT, 0);
        quiet_all();
    endtask

    task automatic t_indep();
        wr(A_CNT0, 7);
        wr(A_CNT1, 0); wr(A_MAT1, 4); wr(A_CTL1, 32'h7);
        edges(10);
        rd_check("R11", "count0 untouched", A_CNT0, 7);
        rd_check("R11", "count1 ran", A_CNT1, 10);
        rd_check("R11", "only status1", A_STAT, 2);
        check("R11", "only irq1", {30'b0, irq}, 2);
        quiet_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_divider();
        t_stop();
        t_load();
        t_hit();
        t_gates();
        t_set_wins();
        t_wrap();
        t_indep();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule